// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Pin Writes

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pin banks. Each bank holds up to 32 pins. A plain 32-bit register port carries a word address, a write strobe, write data and a combinational read word. Through this port software sets, for each bank, which pins are outputs, which outputs actually drive their pads, and what level each output carries. It also reads back the current level of every pin.

Software changes output levels through two write-only registers per bank. One covers the low sixteen pins and one covers the high sixteen. The upper half of the written word is an inverted mask: only pins whose mask bit is clear take the new value from the lower half. A single store can therefore flip any subset of pins without a read-modify-write sequence. Pins above a bank's configured width do not exist. Two pins of the first bank are hard-wired as outputs.

Top module: `pinbank_ctrl`

## Requirements
- R1: A write to offset 0x000 + 8*b changes output data bits 0..15 of bank b. For each i in 0..15, bit i takes wdata[i] when wdata[16+i] is 0 and keeps its value when wdata[16+i] is 1. The change appears on pad_out one cycle after the write.
- R2: A write to offset 0x004 + 8*b works the same way for bits 16..31 of bank b. Bit 16+i takes wdata[i] when wdata[16+i] is 0.
- R3: A read of offset 0x060 + 4*b returns, per pin, the stored output data when the direction bit is 1. When the direction bit is 0 it returns pad_in. A pad_in change becomes visible in this read after exactly two rising clock edges.
- R4: Offset 0x204 + 0x40*b is the readable and writable direction register of bank b. A 1 marks the pin as an output.
- R5: Offset 0x208 + 0x40*b is the readable and writable output-enable register of bank b. pad_oe for a pin is 1 only when both its direction bit and its output-enable bit are 1.
- R6: Bits at or above a bank's configured pin count read as 0 in every register, ignore writes, and keep pad_out and pad_oe at 0. The default configuration has 32, 22, 32 and 32 pins for banks 0 to 3.
- R7: The direction bits of bank 0 pins 7 and 8 always read as 1, and writes that clear them have no effect.
- R8: After reset, all direction, output-enable and output data bits are 0, except the two fixed direction bits of R7.
- R9: Reads of the masked-write offsets and of unmapped offsets return 0. Writes to unmapped offsets or to the read-back data offsets change no register.

Pad bit b*32+i belongs to pin i of bank b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register, word aligned |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NUM_BANKS*32 | Pin levels from the pads |
| pad_out | output | NUM_BANKS*32 | Output data toward the pads |
| pad_oe | output | NUM_BANKS*32 | Pad drive enables |

## Verification
The bench sweeps every bank with masked writes to both halves, using pseudo-random mask and data words plus the all-clear and all-set masks. A design that inverted the mask sense, or that placed the upper-half data at bits 0..15, would corrupt pins that should have held. A design that wrote the whole half would show up under all-set masks. The narrow second bank is driven with all-ones patterns, so a design that stored unimplemented bits would report them in read-back or on the pads. Attempts to clear the fixed pins of bank 0 catch a missing force. A single-bit input step is read on the cycles before and after it crosses the synchroniser, which catches a design that samples one cycle early or late. Writes to holes in the map, to bank numbers past the last bank and to read-back offsets catch a decoder that aliases addresses.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

   localparam int PINS_PER_BANK = 32;
   localparam int HALF_PINS     = 16;
   localparam int SIZE_FIELD_W  = 6;

   // Byte offsets and strides of the register groups.
   localparam int OFS_MASK_LO = 'h000;
   localparam int OFS_MASK_HI = 'h004;
   localparam int STR_MASK    = 8;
   localparam int OFS_LEVEL   = 'h060;
   localparam int STR_LEVEL   = 4;
   localparam int OFS_DIR     = 'h204;
   localparam int OFS_DRV     = 'h208;
   localparam int STR_CFG     = 'h40;

   // Largest bank count whose masked-write window stays below the level window.
   localparam int MAX_BANKS = OFS_LEVEL / STR_MASK;

   function automatic logic [PINS_PER_BANK-1:0] impl_mask(input int pins);
      logic [PINS_PER_BANK-1:0] m;
      for (int i = 0; i < PINS_PER_BANK; i++) m[i] = (i < pins);
      return m;
   endfunction

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
   import pinbank_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] hit_lo,
   output logic [NUM_BANKS-1:0] hit_hi,
   output logic [NUM_BANKS-1:0] hit_level,
   output logic [NUM_BANKS-1:0] hit_dir,
   output logic [NUM_BANKS-1:0] hit_drv
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFS_MASK_LO + STR_MASK  * b);
      localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFS_MASK_HI + STR_MASK  * b);
      localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(OFS_LEVEL   + STR_LEVEL * b);
      localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFS_DIR     + STR_CFG   * b);
      localparam logic [ADDR_W-1:0] A_DRV = ADDR_W'(OFS_DRV     + STR_CFG   * b);

      assign hit_lo[b]    = (addr == A_LO);
      assign hit_hi[b]    = (addr == A_HI);
      assign hit_level[b] = (addr == A_LVL);
      assign hit_dir[b]   = (addr == A_DIR);
      assign hit_drv[b]   = (addr == A_DRV);
   end

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         q      <= '0;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end

endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
   import pinbank_pkg::*;
#(
   parameter int PINS      = 32,
   parameter bit HAS_FIXED = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_lo,
   input  logic                     wr_hi,
   input  logic                     wr_dir,
   input  logic                     wr_drv,
   input  logic [31:0]              wdata,
   input  logic [PINS_PER_BANK-1:0] level_in,
   output logic [PINS_PER_BANK-1:0] dir_q,
   output logic [PINS_PER_BANK-1:0] drv_q,
   output logic [PINS_PER_BANK-1:0] out_q,
   output logic [PINS_PER_BANK-1:0] level_rd
);

   localparam logic [PINS_PER_BANK-1:0] IMPL = impl_mask(PINS);
   localparam logic [PINS_PER_BANK-1:0] FIXED =
      HAS_FIXED ? (PINS_PER_BANK'(1) << 7) | (PINS_PER_BANK'(1) << 8) : '0;
   localparam logic [PINS_PER_BANK-1:0] DIR_RST = FIXED & IMPL;

   logic [PINS_PER_BANK-1:0] out_nxt;

   always_comb begin
      out_nxt = out_q;
      for (int i = 0; i < HALF_PINS; i++) begin
         if (wr_lo && !wdata[HALF_PINS + i]) out_nxt[i]             = wdata[i];
         if (wr_hi && !wdata[HALF_PINS + i]) out_nxt[HALF_PINS + i] = wdata[i];
      end
      out_nxt = out_nxt & IMPL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_RST;
         drv_q <= '0;
         out_q <= '0;
      end else begin
         if (wr_dir)          dir_q <= (wdata & IMPL) | DIR_RST;
         if (wr_drv)          drv_q <= wdata & IMPL;
         if (wr_lo || wr_hi)  out_q <= out_nxt;
      end
   end

   assign level_rd = ((dir_q & out_q) | (~dir_q & level_in)) & IMPL;

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
   import pinbank_pkg::*;
#(
   parameter int                               NUM_BANKS  = 4,
   parameter int                               ADDR_W     = 12,
   parameter logic [NUM_BANKS*SIZE_FIELD_W-1:0] BANK_SIZES =
      {6'd32, 6'd32, 6'd22, 6'd32}
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_we,
   input  logic [31:0]                   bus_wdata,
   output logic [31:0]                   bus_rdata,
   input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_in,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe
);

   localparam int TOTAL_PINS = NUM_BANKS * PINS_PER_BANK;
   localparam int ADDR_SPAN  = OFS_DRV + STR_CFG * (NUM_BANKS - 1) + 4;

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("pinbank_ctrl: NUM_BANKS out of range");
   end
   if ((1 << ADDR_W) < ADDR_SPAN) begin : g_bad_addr
      $error("pinbank_ctrl: ADDR_W too narrow for the register map");
   end

   logic [NUM_BANKS-1:0] hit_lo, hit_hi, hit_level, hit_dir, hit_drv;
   logic [TOTAL_PINS-1:0] pin_sync;
   logic [31:0] rd_part [NUM_BANKS];

   pinbank_decode #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W)
   ) u_decode (
      .addr      (bus_addr),
      .hit_lo    (hit_lo),
      .hit_hi    (hit_hi),
      .hit_level (hit_level),
      .hit_dir   (hit_dir),
      .hit_drv   (hit_drv)
   );

   pinbank_sync #(
      .WIDTH (TOTAL_PINS)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int PINS = int'(BANK_SIZES[b*SIZE_FIELD_W +: SIZE_FIELD_W]);

      if (PINS < 1 || PINS > PINS_PER_BANK) begin : g_bad_size
         $error("pinbank_ctrl: bank pin count out of range");
      end

      logic [PINS_PER_BANK-1:0] dir_q, drv_q, out_q, level_rd;

      pinbank_bank #(
         .PINS      (PINS),
         .HAS_FIXED (b == 0)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_lo    (bus_we && hit_lo[b]),
         .wr_hi    (bus_we && hit_hi[b]),
         .wr_dir   (bus_we && hit_dir[b]),
         .wr_drv   (bus_we && hit_drv[b]),
         .wdata    (bus_wdata),
         .level_in (pin_sync[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .dir_q    (dir_q),
         .drv_q    (drv_q),
         .out_q    (out_q),
         .level_rd (level_rd)
      );

      assign pad_out[b*PINS_PER_BANK +: PINS_PER_BANK] = out_q;
      assign pad_oe [b*PINS_PER_BANK +: PINS_PER_BANK] = dir_q & drv_q;

      assign rd_part[b] = ({32{hit_dir[b]}}   & dir_q)
                        | ({32{hit_drv[b]}}   & drv_q)
                        | ({32{hit_level[b]}} & level_rd);
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | rd_part[b];
   end

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
   import pinbank_pkg::*;
#(
   parameter int                               NUM_BANKS  = 4,
   parameter int                               ADDR_W     = 12,
   parameter logic [NUM_BANKS*SIZE_FIELD_W-1:0] BANK_SIZES = '0
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic                          bus_we,
   input logic [31:0]                   bus_wdata,
   input logic [31:0]                   bus_rdata,
   input logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
   input logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe
);

   localparam logic [ADDR_W-1:0] A_LO0  = ADDR_W'(OFS_MASK_LO);
   localparam logic [ADDR_W-1:0] A_HI0  = ADDR_W'(OFS_MASK_HI);
   localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(OFS_DIR);

   // R1: a clear mask loads the data half onto the low pins of bank 0
   a_r1_clear_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_LO0 && bus_wdata[31:16] == 16'h0000)
      |=> (pad_out[15:0] == $past(bus_wdata[15:0])));

   // R1: a full mask leaves the low pins untouched
   a_r1_full_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_LO0 && bus_wdata[31:16] == 16'hFFFF)
      |=> $stable(pad_out[15:0]));

   // R7: fixed output pins of bank 0 always read back as outputs
   a_r7_fixed_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_DIR0) |-> (bus_rdata[8:7] == 2'b11));

   // R9: masked-write offsets read as zero
   a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_LO0 || bus_addr == A_HI0) |-> (bus_rdata == 32'h0));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int PINS = int'(BANK_SIZES[b*SIZE_FIELD_W +: SIZE_FIELD_W]);
      if (PINS < PINS_PER_BANK) begin : g_narrow
         // R6: missing pins never drive
         a_r6_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_out[b*PINS_PER_BANK + PINS +: PINS_PER_BANK - PINS] == '0) &&
            (pad_oe [b*PINS_PER_BANK + PINS +: PINS_PER_BANK - PINS] == '0));
      end
   end

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
   .NUM_BANKS  (NUM_BANKS),
   .ADDR_W     (ADDR_W),
   .BANK_SIZES (BANK_SIZES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;

   localparam int NB = 4;
   localparam int AW = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [AW-1:0]    addr = 12'hFFC;
   logic             we = 1'b0;
   logic [31:0]      wdata = '0;
   logic [31:0]      rdata;
   logic [NB*32-1:0] pin = '0;
   logic [NB*32-1:0] pout, poe;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // bench model
   logic [31:0] m_dir [NB];
   logic [31:0] m_drv [NB];
   logic [31:0] m_out [NB];
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;

   pinbank_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata),
      .pad_in(pin), .pad_out(pout), .pad_oe(poe)
   );

   function automatic int bank_pins(input int b);
      return (b == 1) ? 22 : 32;
   endfunction

   function automatic logic [31:0] impl(input int b);
      logic [31:0] m;
      for (int i = 0; i < 32; i++) m[i] = (i < bank_pins(b));
      return m;
   endfunction

   function automatic logic [31:0] fixed(input int b);
      return (b == 0) ? 32'h0000_0180 : 32'h0;
   endfunction

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int b = 0; b < NB; b++) begin
         m_dir[b] = fixed(b);
         m_drv[b] = '0;
         m_out[b] = '0;
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0; addr = 12'hFFC;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wr_masked(input int b, input bit hi, input logic [31:0] d);
      bus_wr(AW'(8*b + (hi ? 4 : 0)), d);
      for (int i = 0; i < 16; i++)
         if (!d[16+i]) m_out[b][(hi ? 16 : 0) + i] = d[i];
      m_out[b] = m_out[b] & impl(b);
   endtask

   task automatic wr_dir(input int b, input logic [31:0] d);
      bus_wr(AW'('h204 + 64*b), d);
      m_dir[b] = (d & impl(b)) | fixed(b);
   endtask

   task automatic wr_drv(input int b, input logic [31:0] d);
      bus_wr(AW'('h208 + 64*b), d);
      m_drv[b] = d & impl(b);
   endtask

   // full comparison of every register and pad against the model
   task automatic check_all(input string tag);
      logic [31:0] r, lvl;
      for (int b = 0; b < NB; b++) begin
         bus_rd(AW'('h204 + 64*b), r);
         check(tag, $sformatf("dir bank%0d", b), r, m_dir[b]);
         bus_rd(AW'('h208 + 64*b), r);
         check(tag, $sformatf("drv bank%0d", b), r, m_drv[b]);
         lvl = ((m_dir[b] & m_out[b]) | (~m_dir[b] & pin[b*32 +: 32])) & impl(b);
         bus_rd(AW'('h060 + 4*b), r);
         check(tag, $sformatf("level bank%0d", b), r, lvl);
         check(tag, $sformatf("pad_out bank%0d", b), pout[b*32 +: 32], m_out[b]);
         check(tag, $sformatf("pad_oe bank%0d", b), poe[b*32 +: 32], m_dir[b] & m_drv[b]);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: reset state
      check_all("R8");

      // R9: write-only and unmapped reads
      for (int b = 0; b < NB; b++) begin
         bus_rd(AW'(8*b), r);     check("R9", "lo read", r, 32'h0);
         bus_rd(AW'(8*b + 4), r); check("R9", "hi read", r, 32'h0);
      end
      bus_rd(12'h100, r); check("R9", "unmapped 0x100", r, 32'h0);
      bus_rd(12'h200, r); check("R9", "unmapped 0x200", r, 32'h0);
      bus_rd(12'h070, r); check("R9", "bank4 level", r, 32'h0);

      // R4 R5 R6 R7: configuration patterns on every bank
      for (int b = 0; b < NB; b++) begin
         wr_dir(b, 32'hFFFF_FFFF); wr_drv(b, 32'hFFFF_FFFF);
         check_all("R6");
         wr_dir(b, 32'h0000_0000); wr_drv(b, 32'h0F0F_F0F0);
         check_all("R7");
         wr_dir(b, 32'hA5A5_5A5A); wr_drv(b, 32'h3C3C_C3C3);
         check_all("R5");
         wr_dir(b, rnd()); wr_drv(b, rnd());
         check_all("R4");
      end

      // R1 R2: masked-write sweep, both halves of each bank
      for (int b = 0; b < NB; b++) begin
         wr_dir(b, 32'hFFFF_FFFF); wr_drv(b, 32'hFFFF_FFFF);
         wr_masked(b, 0, 32'h0000_FFFF); check_all("R1");
         wr_masked(b, 1, 32'h0000_FFFF); check_all("R2");
         wr_masked(b, 0, 32'hFFFF_0000); check_all("R1");
         wr_masked(b, 1, 32'hFFFF_0000); check_all("R2");
         for (int k = 0; k < 6; k++) begin
            wr_masked(b, 0, rnd()); check_all("R1");
            wr_masked(b, 1, rnd()); check_all("R2");
         end
         wr_masked(b, 1, 32'hFFFE_0000); check_all("R2");
         wr_masked(b, 0, 32'h7FFF_0000); check_all("R1");
      end

      // R3: inputs mixed with outputs
      for (int b = 0; b < NB; b++) begin
         wr_dir(b, 32'h00FF_FF00);
         wr_masked(b, 0, 32'h0000_A5A5);
         wr_masked(b, 1, 32'h0000_5A5A);
      end
      @(negedge clk); pin = {rnd(), rnd(), rnd(), rnd()};
      repeat (3) @(negedge clk);
      check_all("R3");
      @(negedge clk); pin = ~pin;
      repeat (3) @(negedge clk);
      check_all("R3");

      // R3: two-edge synchroniser latency on bank 2 pin 3 (an input)
      addr = AW'('h060 + 8);
      @(negedge clk); pin[64+3] = ~pin[64+3];
      @(negedge clk); #1;
      check("R3", "level after one edge", {31'b0, rdata[3]}, {31'b0, ~pin[64+3]});
      @(negedge clk); #1;
      check("R3", "level after two edges", {31'b0, rdata[3]}, {31'b0, pin[64+3]});

      // R9: writes to holes, absent banks and read-back offsets
      bus_wr(12'h100, 32'hFFFF_FFFF);
      bus_wr(12'h020, 32'h0000_FFFF);
      bus_wr(12'h024, 32'h0000_FFFF);
      bus_wr(12'h060, 32'hFFFF_FFFF);
      bus_wr(12'h068, 32'hFFFF_FFFF);
      bus_wr(12'h304, 32'hFFFF_FFFF);
      bus_wr(12'h200, 32'hFFFF_FFFF);
      check_all("R9");

      // R8: second reset
      @(negedge clk); rst_n = 1'b0;
      model_reset();
      @(negedge clk); rst_n = 1'b1;
      check_all("R8");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule